// File: doc/BRIEF.md
# Multilevel State-to-Gate Decoder with Dead-Time Insertion

This block sits between a multilevel modulator and the gate drivers of a three-phase diode-clamped converter. For every phase it takes a commanded level number and turns it into the gate commands for that phase's upper switches and their complementary lower switches. The mapping is a thermometer code: a level k turns on the k lowest-numbered upper switches and leaves the rest off. Every upper switch has a lower partner, and the two are always driven in opposition.

Each upper/lower pair has its own small state machine that inserts a programmable dead time. Whenever a device of a pair is about to turn on, both devices are first held off for `dead_cycles` clock cycles. A device that has to turn off does so at once. If the command for a pair changes again while its dead time is still running, the count starts over. For checking, the block counts the upper gates that are actually applied and reports that count as a rebuilt level per phase. An out-of-range command is clamped to the top level and sets a sticky error flag.

The pair state machine has five states. PAIR_IDLE (both off) is entered on reset only. PAIR_LOW means the lower device is on, and PAIR_HIGH means the upper device is on. PAIR_GAP_UP and PAIR_GAP_DN hold both devices off while the count runs toward the upper or lower device. The transitions are as follows. From IDLE, LOW or HIGH, a target that differs from the device now on leads to the matching GAP state, or straight to the target state when `dead_cycles` is 0. A GAP state whose target flips goes to the opposite GAP state with the count reloaded (restart). A GAP state whose count reaches zero goes to its target state.

Top module: `mlevel_gate_decoder`

## Requirements
- R1: Phase p's level is the unsigned field `state_cmd[p*SW +: SW]`, with SW = $clog2(LEVELS). Pair i (1..LEVELS-1) of phase p is bit p*(LEVELS-1)+(i-1) of `gate_up` and of `gate_dn`.
- R2: Once settled, upper gate i of a phase is on exactly when the phase level is at least i, and lower gate i is its complement.
- R3: `state_fb` of each phase always equals the number of that phase's upper gates that are on. Once settled, this equals the commanded (clamped) level.
- R4: The upper and lower gates of a pair are never on together.
- R5: When a pair's device must turn on, both gates of the pair are off for exactly `dead_cycles` clock cycles after the edge that samples the new command. The device turns on at the following edge. A value of 0 switches at the sampling edge.
- R6: A device whose pair target changes turns off at the very edge that samples the new command.
- R7: If a pair's target flips while its dead time runs, the count restarts from `dead_cycles`, and both gates stay off until the new count expires.
- R8: A phase command above LEVELS-1 is treated as LEVELS-1.
- R9: `range_err` sets on the edge after any out-of-range command and stays set until reset.
- R10: While reset is active, all gates are off, `state_fb` is 0 and `range_err` is 0. After release, each pair reaches its target through a full dead time.
- R11: Pairs whose target does not change keep their gates unchanged while other pairs of the same or other phases switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| state_cmd | input | PHASES*SW | Commanded level per phase |
| dead_cycles | input | DT_W | Dead time in clock cycles |
| gate_up | output | PHASES*(LEVELS-1) | Upper switch gates |
| gate_dn | output | PHASES*(LEVELS-1) | Complementary lower switch gates |
| state_fb | output | PHASES*SW | Level rebuilt from applied upper gates |
| range_err | output | 1 | Sticky out-of-range command flag |

## Verification
With five levels on three phases, the bench walks through every one of the 125 level combinations in turn. It cycles the dead time through 0, 1 and 3, and checks each cycle of the window arithmetically. Pairs that keep their target must stay put, pairs that change must show both gates off, and the final state must be the thermometer code. This separates a wrong thermometer mapping, a missing or off-by-one gap, and a late turn-off. A target flipped in the middle of a gap shows whether the count restarts or resumes. Out-of-range commands followed by valid ones show both the clamp and that the error flag holds.

// File: rtl/mlgd_pkg.sv
package mlgd_pkg;

    typedef enum logic [2:0] {
        PAIR_IDLE   = 3'd0,
        PAIR_LOW    = 3'd1,
        PAIR_HIGH   = 3'd2,
        PAIR_GAP_UP = 3'd3,
        PAIR_GAP_DN = 3'd4
    } pair_state_e;

endpackage

// File: rtl/mlgd_level_clamp.sv
module mlgd_level_clamp #(
    parameter int LEVELS = 5,
    parameter int SW     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SW-1:0]     raw_lvl,
    output logic [SW-1:0]     lvl,
    output logic [LEVELS-2:0] thermo,
    output logic              over
);
    localparam int TOP = LEVELS - 1;

    always_comb begin
        over = (int'(raw_lvl) > TOP);
        lvl  = over ? SW'(TOP) : raw_lvl;
    end

    for (genvar i = 0; i < LEVELS - 1; i++) begin : g_thermo
        assign thermo[i] = (int'(lvl) >= i + 1);
    end

    // R8: clamped level never exceeds the top level
    p_clamp_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(lvl) <= TOP);

    // R2: thermometer code has only contiguous low ones
    p_thermo_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((thermo + 1'b1) & thermo) == '0);

endmodule

// File: rtl/mlgd_pair_fsm.sv
module mlgd_pair_fsm
    import mlgd_pkg::*;
#(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            want_up,
    input  logic [DT_W-1:0] dead,
    output logic            gate_up,
    output logic            gate_dn
);
    pair_state_e state_q, state_d;
    logic [DT_W-1:0] cnt_q, cnt_d;
    logic            no_gap;
    logic [DT_W-1:0] reload;

    assign no_gap = (dead == '0);
    assign reload = dead - DT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PAIR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PAIR_IDLE: begin
                cnt_d = reload;
                if (want_up) state_d = no_gap ? PAIR_HIGH : PAIR_GAP_UP;
                else         state_d = no_gap ? PAIR_LOW  : PAIR_GAP_DN;
            end
            PAIR_LOW: begin
                if (want_up) begin
                    cnt_d   = reload;
                    state_d = no_gap ? PAIR_HIGH : PAIR_GAP_UP;
                end
            end
            PAIR_HIGH: begin
                if (!want_up) begin
                    cnt_d   = reload;
                    state_d = no_gap ? PAIR_LOW : PAIR_GAP_DN;
                end
            end
            PAIR_GAP_UP: begin
                if (!want_up) begin
                    cnt_d   = reload;
                    state_d = no_gap ? PAIR_LOW : PAIR_GAP_DN;
                end else if (cnt_q == '0) begin
                    state_d = PAIR_HIGH;
                end else begin
                    cnt_d = cnt_q - DT_W'(1);
                end
            end
            PAIR_GAP_DN: begin
                if (want_up) begin
                    cnt_d   = reload;
                    state_d = no_gap ? PAIR_HIGH : PAIR_GAP_UP;
                end else if (cnt_q == '0) begin
                    state_d = PAIR_LOW;
                end else begin
                    cnt_d = cnt_q - DT_W'(1);
                end
            end
            default: begin
                state_d = PAIR_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        gate_up = 1'b0;
        gate_dn = 1'b0;
        unique case (state_q)
            PAIR_HIGH: gate_up = 1'b1;
            PAIR_LOW:  gate_dn = 1'b1;
            default: begin
                gate_up = 1'b0;
                gate_dn = 1'b0;
            end
        endcase
    end

    // R4: never both devices on
    p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_up && gate_dn));

    // R5: upper device cannot follow lower device directly when a gap is set
    p_gap_before_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_dn && dead != '0) |=> !gate_up);

    // R5: lower device cannot follow upper device directly when a gap is set
    p_gap_before_dn_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_up && dead != '0) |=> !gate_dn);

    // R6: a device that loses its target is off after the next edge
    p_fast_off_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_up && !want_up) |=> !gate_up);

    p_fast_off_dn_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_dn && want_up) |=> !gate_dn);

    // R7: a flip inside an upward gap with a long dead time keeps both off
    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PAIR_GAP_UP && !want_up && dead > DT_W'(1)) |=> (!gate_up && !gate_dn));

endmodule

// File: rtl/mlgd_phase.sv
module mlgd_phase #(
    parameter int LEVELS = 5,
    parameter int DT_W   = 4,
    parameter int SW     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SW-1:0]     raw_lvl,
    input  logic [DT_W-1:0]   dead,
    output logic [LEVELS-2:0] up,
    output logic [LEVELS-2:0] dn,
    output logic [SW-1:0]     fb,
    output logic              over
);
    localparam int NP = LEVELS - 1;

    logic [SW-1:0] lvl;
    logic [NP-1:0] thermo;

    mlgd_level_clamp #(.LEVELS(LEVELS), .SW(SW)) u_clamp (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_lvl (raw_lvl),
        .lvl     (lvl),
        .thermo  (thermo),
        .over    (over)
    );

    for (genvar i = 0; i < NP; i++) begin : g_pair
        mlgd_pair_fsm #(.DT_W(DT_W)) u_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .want_up (thermo[i]),
            .dead    (dead),
            .gate_up (up[i]),
            .gate_dn (dn[i])
        );
    end

    always_comb begin
        fb = '0;
        for (int i = 0; i < NP; i++) begin
            fb = fb + SW'(up[i]);
        end
    end

    // R3: with every pair steady and the level unchanged, feedback equals level
    p_fb_settled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (((up ^ dn) == '1) && $stable(lvl)) |-> (fb == lvl));

endmodule

// File: rtl/mlevel_gate_decoder.sv
module mlevel_gate_decoder #(
    parameter int LEVELS = 5,
    parameter int PHASES = 3,
    parameter int DT_W   = 4,
    localparam int SW    = (LEVELS > 2) ? $clog2(LEVELS) : 1,
    localparam int NP    = LEVELS - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PHASES*SW-1:0] state_cmd,
    input  logic [DT_W-1:0]      dead_cycles,
    output logic [PHASES*NP-1:0] gate_up,
    output logic [PHASES*NP-1:0] gate_dn,
    output logic [PHASES*SW-1:0] state_fb,
    output logic                 range_err
);
    logic [PHASES-1:0] over;
    logic              err_q;

    for (genvar p = 0; p < PHASES; p++) begin : g_phase
        mlgd_phase #(.LEVELS(LEVELS), .DT_W(DT_W), .SW(SW)) u_phase (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_lvl (state_cmd[p*SW +: SW]),
            .dead    (dead_cycles),
            .up      (gate_up[p*NP +: NP]),
            .dn      (gate_dn[p*NP +: NP]),
            .fb      (state_fb[p*SW +: SW]),
            .over    (over[p])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_q | (|over);
    end

    assign range_err = err_q;

    // R9: flag holds once set
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        range_err |=> range_err);

    // R9: an out-of-range command sets the flag
    p_err_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|over) |=> range_err);

endmodule

// File: tb/mlevel_gate_decoder_tb.sv
`timescale 1ns/1ps
module mlevel_gate_decoder_tb;
    localparam int L  = 5;
    localparam int P  = 3;
    localparam int DW = 4;
    localparam int SW = 3;
    localparam int NP = L - 1;

    logic clk = 1'b0;
    logic rst_n;
    logic [P*SW-1:0] st;
    logic [DW-1:0]   dt;
    logic [P*NP-1:0] gu, gd;
    logic [P*SW-1:0] fb;
    logic            err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [P*NP-1:0] prev;

    always #2.5 clk = ~clk;

    mlevel_gate_decoder #(.LEVELS(L), .PHASES(P), .DT_W(DW)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_cmd   (st),
        .dead_cycles (dt),
        .gate_up     (gu),
        .gate_dn     (gd),
        .state_fb    (fb),
        .range_err   (err)
    );

    function automatic int clampv(int s);
        return (s > L - 1) ? L - 1 : s;
    endfunction

    function automatic logic [P*NP-1:0] tvec(int a, int b, int c);
        int s[P];
        logic [P*NP-1:0] v;
        s[0] = clampv(a); s[1] = clampv(b); s[2] = clampv(c);
        v = '0;
        for (int p = 0; p < P; p++)
            for (int i = 1; i <= NP; i++)
                v[p*NP + i - 1] = (s[p] >= i);
        return v;
    endfunction

    function automatic logic [P*SW-1:0] fbvec(logic [P*NP-1:0] hi);
        logic [P*SW-1:0] v;
        v = '0;
        for (int p = 0; p < P; p++) begin
            int n;
            n = 0;
            for (int i = 0; i < NP; i++) n += int'(hi[p*NP + i]);
            v[p*SW +: SW] = SW'(n);
        end
        return v;
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic apply(int a, int b, int c, int d);
        logic [P*NP-1:0] nw;
        st = {SW'(c), SW'(b), SW'(a)};
        dt = DW'(d);
        nw = tvec(a, b, c);
        for (int k = 0; k <= d; k++) begin
            @(negedge clk);
            if (k < d) begin
                chk(gu == (prev & nw), "R5/R6/R11", "gap upper", gu, prev & nw);
                chk(gd == (~prev & ~nw), "R4/R5/R11", "gap lower", gd, ~prev & ~nw);
                chk(fb == fbvec(prev & nw), "R3", "gap feedback", fb, fbvec(prev & nw));
            end else begin
                chk(gu == nw, "R2/R8", "settled upper", gu, nw);
                chk(gd == ~nw, "R2", "settled lower", gd, ~nw);
                chk(fb == fbvec(nw), "R3/R1", "settled feedback", fb, fbvec(nw));
            end
        end
        prev = nw;
    endtask

    initial begin
        rst_n = 1'b0;
        st    = '0;
        dt    = DW'(2);
        prev  = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(gu == '0, "R10", "reset upper", gu, 0);
        chk(gd == '0, "R10", "reset lower", gd, 0);
        chk(fb == '0, "R10", "reset feedback", fb, 0);
        chk(err == 1'b0, "R10", "reset error", err, 0);
        rst_n = 1'b1;
        // R10: both off for the dead time after release, then lower on
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (k < 2) chk(gu == '0 && gd == '0, "R10", "release gap", gd, 0);
            else       chk(gd == '1 && gu == '0, "R10", "release settled", gd, '1);
        end
        prev = tvec(0, 0, 0);

        // R2, R3, R5, R6, R11: full sweep of levels
        for (int a = 0; a < L; a++)
            for (int b = 0; b < L; b++)
                for (int c = 0; c < L; c++) begin
                    int m;
                    m = (a + b + c) % 3;
                    apply(a, b, c, (m == 0) ? 0 : (m == 1) ? 1 : 3);
                end
        chk(err == 1'b0, "R9", "no error on valid levels", err, 0);

        // R7: flip inside the gap restarts the count
        st = '0;
        dt = DW'(4);
        repeat (2) begin
            @(negedge clk);
            chk(gu == '0 && gd == '0, "R7", "first gap", gu, 0);
        end
        st = {SW'(4), SW'(4), SW'(4)};
        for (int k = 0; k <= 4; k++) begin
            @(negedge clk);
            if (k < 4) chk(gu == '0 && gd == '0, "R7", "restarted gap", {gu, gd}, 0);
            else       chk(gu == '1 && gd == '0, "R7", "restart settled", gu, '1);
        end
        prev = tvec(4, 4, 4);

        // R8, R9: out-of-range clamps and sets sticky flag
        apply(1, 7, 2, 1);
        chk(err == 1'b1, "R9", "error set", err, 1);
        apply(6, 0, 5, 0);
        chk(fb == {SW'(4), SW'(0), SW'(4)}, "R8", "clamped feedback", fb, {SW'(4), SW'(0), SW'(4)});
        apply(0, 3, 0, 2);
        chk(err == 1'b1, "R9", "error held", err, 1);

        // R10: reset again clears everything
        rst_n = 1'b0;
        @(negedge clk);
        chk(gu == '0 && gd == '0, "R10", "second reset gates", {gu, gd}, 0);
        chk(err == 1'b0, "R10", "second reset error", err, 0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule